// File: doc/BRIEF.md
# Bank-Switched Dual-Port Synchronous Memory

This block is a two-port synchronous memory whose storage is divided into independent single-port banks. Each port, left and right, names a bank with a 6-bit bank address and a word inside that bank with an in-bank address. Both ports run at the same time whenever they work in different banks. When both ports select the same bank in the same cycle, the left port is served and both ports see a one-cycle collision flag. In the full configuration there are 64 banks of 4096 words (12-bit in-bank address). The default parameters keep the 64 banks and cut the in-bank depth to 16 words, so the storage stays small at elaboration.

Every port input is captured on the rising clock edge: data, bank, word address, byte enables, chip enables, direction, output enable and output mode. Each port has its own address counter. The counter loads on an address strobe, steps by one inside the current bank, and can return to the last strobed address. Each port chooses its read timing on its own. In flow-through mode read data appears one edge after the command is registered. In pipelined mode it passes through one more output register. Both ports share a single clock, so the same-bank rule reduces to a compare of registered bank addresses.

Top module: `bank_dpram`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released with both ports idle, `validL`, `validR`, `collL` and `collR` are 0 and `doutL`, `doutR` are 0.
- R2: A word written at bank b, word w is returned by a later read of bank b, word w; words in other banks or at other in-bank addresses are not affected.
- R3: Byte enables are active low. `ubN` guards data bits 17:9 and `lbN` guards bits 8:0, and a write changes only the halves whose enable is low.
- R4: A port is selected only when `ce0N` is 0 and `ce1` is 1. An unselected write leaves storage unchanged, and an unselected read gives `valid` 0 with `dout` 0.
- R5: `rdWrN` set to 1 makes a selected access a read; set to 0 it makes it a write.
- R6: In flow-through mode (`pipe` 0), a read registered at clock edge k drives `valid` 1 and its data on `dout` after edge k+1.
- R7: In pipelined mode (`pipe` 1), the same read is presented after edge k+2. After edge k+1 the output still reflects the earlier cycle.
- R8: When `addrStb` is 1, the access of that cycle uses the external word address, and that address becomes the remembered strobe address.
- R9: When `cntEn` is 1 with `addrStb` and `rptEn` both 0, the in-bank address advances by one and wraps from the last word to 0 without changing bank. With all three at 0 the address holds.
- R10: When `rptEn` is 1 and `addrStb` is 0, the address returns to the last strobed address even if `cntEn` is 1. When `addrStb` and `rptEn` are both 1, the strobe wins.
- R11: `oeN` is active low and registered with the command. A read issued with `oeN` at 1 gives `valid` 0 and `dout` 0.
- R12: When both ports are selected in the same bank in the same cycle, the left access completes. The right write is discarded, the right read repeats the previous right read data with `valid` 1, and `collL` and `collR` are 1 for that one output cycle.
- R13: Accesses by both ports in the same cycle to different banks both complete, including a read of a bank while the other port writes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pipeL | input | 1 | Left output mode: 1 pipelined, 0 flow-through |
| ce0NL | input | 1 | Left chip enable, active low |
| ce1L | input | 1 | Left chip enable, active high |
| rdWrNL | input | 1 | Left direction: 1 read, 0 write |
| addrStbL | input | 1 | Left address strobe (loads counter) |
| cntEnL | input | 1 | Left counter step enable |
| rptEnL | input | 1 | Left return to last strobed address |
| bankL | input | BankBits | Left bank address |
| wordL | input | WordBits | Left in-bank word address |
| ubNL | input | 1 | Left upper-half write enable, active low |
| lbNL | input | 1 | Left lower-half write enable, active low |
| oeNL | input | 1 | Left output enable, active low |
| dinL | input | DataBits | Left write data |
| doutL | output | DataBits | Left read data, 0 when not valid |
| validL | output | 1 | Left read data valid |
| collL | output | 1 | Left same-bank collision flag |
| pipeR | input | 1 | Right output mode: 1 pipelined, 0 flow-through |
| ce0NR | input | 1 | Right chip enable, active low |
| ce1R | input | 1 | Right chip enable, active high |
| rdWrNR | input | 1 | Right direction: 1 read, 0 write |
| addrStbR | input | 1 | Right address strobe |
| cntEnR | input | 1 | Right counter step enable |
| rptEnR | input | 1 | Right return to last strobed address |
| bankR | input | BankBits | Right bank address |
| wordR | input | WordBits | Right in-bank word address |
| ubNR | input | 1 | Right upper-half write enable, active low |
| lbNR | input | 1 | Right lower-half write enable, active low |
| oeNR | input | 1 | Right output enable, active low |
| dinR | input | DataBits | Right write data |
| doutR | output | DataBits | Right read data, 0 when not valid |
| validR | output | 1 | Right read data valid |
| collR | output | 1 | Right same-bank collision flag |

## Verification
The table-driven part applies a full write and then a masked rewrite at scattered bank and word positions, covering each byte-enable combination. This separates correct half-word masking from whole-word or swapped-half writes. Counter bursts that cross the last in-bank word show whether wrapping stays inside the bank. Mixed strobe, repeat and step requests show whether the priority order is right. Paired same-cycle accesses, first in one bank and then in two different banks, distinguish the collision rule (left wins, right write lost, right read repeats) from independent operation. The flow-through and pipelined sequences are sampled at both candidate cycles, which exposes any one-edge latency error.

// File: rtl/bank_dpram_pkg.sv
package bank_dpram_pkg;

  // Registered command strobes handed from a port's control to the datapath
  typedef struct packed {
    logic       sel;     // both chip enables active
    logic       wr;      // write (else read)
    logic [1:0] byteWe;  // [1] upper half, [0] lower half
    logic       oe;      // output enabled
    logic       pipe;    // pipelined output mode
  } portCmd_t;

endpackage

// File: rtl/bank_dpram_port.sv
module bank_dpram_port
  import bank_dpram_pkg::*;
#(
  parameter int BankBits = 6,
  parameter int WordBits = 4,
  parameter int DataBits = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ce0N,
  input  logic                ce1,
  input  logic                rdWrN,
  input  logic                addrStb,
  input  logic                cntEn,
  input  logic                rptEn,
  input  logic                ubN,
  input  logic                lbN,
  input  logic                oeN,
  input  logic                pipeSel,
  input  logic [BankBits-1:0] bankIn,
  input  logic [WordBits-1:0] wordIn,
  input  logic [DataBits-1:0] dataIn,
  output portCmd_t            cmd,
  output logic [BankBits-1:0] bankQ,
  output logic [WordBits-1:0] wordQ,
  output logic [DataBits-1:0] dataQ
);

  localparam logic [WordBits-1:0] WordOne = WordBits'(1);

  logic [WordBits-1:0] stbWord;
  logic [WordBits-1:0] nextWord;

  // Counter source: strobe, then repeat, then step, else hold
  always_comb begin
    if (addrStb)     nextWord = wordIn;
    else if (rptEn)  nextWord = stbWord;
    else if (cntEn)  nextWord = wordQ + WordOne;
    else             nextWord = wordQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd     <= '0;
      bankQ   <= '0;
      wordQ   <= '0;
      stbWord <= '0;
      dataQ   <= '0;
    end else begin
      cmd.sel    <= !ce0N && ce1;
      cmd.wr     <= !rdWrN;
      cmd.byteWe <= {!ubN, !lbN};
      cmd.oe     <= !oeN;
      cmd.pipe   <= pipeSel;
      bankQ      <= bankIn;
      wordQ      <= nextWord;
      dataQ      <= dataIn;
      if (addrStb) stbWord <= wordIn;
    end
  end

endmodule

// File: rtl/bank_dpram_core.sv
module bank_dpram_core
  import bank_dpram_pkg::*;
#(
  parameter int BankBits = 6,
  parameter int WordBits = 4,
  parameter int DataBits = 18
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  portCmd_t [1:0]            cmd,
  input  logic [1:0][BankBits-1:0]  bankQ,
  input  logic [1:0][WordBits-1:0]  wordQ,
  input  logic [1:0][DataBits-1:0]  dataQ,
  output logic [1:0][DataBits-1:0]  dataOut,
  output logic [1:0]                dataValid,
  output logic [1:0]                clashFlag
);

  localparam int AddrBits = BankBits + WordBits;
  localparam int Depth    = 1 << AddrBits;
  localparam int HalfBits = DataBits / 2;

  logic [DataBits-1:0]       store [Depth];
  logic [1:0][AddrBits-1:0]  idx;
  logic                      clash;
  logic [1:0]                served;

  // Same-bank access by both ports: left keeps the bank
  always_comb begin
    clash     = cmd[0].sel && cmd[1].sel && (bankQ[0] == bankQ[1]);
    served[0] = cmd[0].sel;
    served[1] = cmd[1].sel && !clash;
  end

  // Storage writes, one byte half at a time
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (served[p] && cmd[p].wr) begin
        if (cmd[p].byteWe[0])
          store[idx[p]][HalfBits-1:0] <= dataQ[p][HalfBits-1:0];
        if (cmd[p].byteWe[1])
          store[idx[p]][DataBits-1:HalfBits] <= dataQ[p][DataBits-1:HalfBits];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_out
    logic [DataBits-1:0] rdData;
    logic [DataBits-1:0] pipeData;
    logic                rdValid;
    logic                pipeValid;
    logic                clashQ;

    assign idx[p] = {bankQ[p], wordQ[p]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData    <= '0;
        pipeData  <= '0;
        rdValid   <= 1'b0;
        pipeValid <= 1'b0;
        clashQ    <= 1'b0;
      end else begin
        rdValid   <= cmd[p].sel && !cmd[p].wr && cmd[p].oe;
        if (served[p] && !cmd[p].wr) rdData <= store[idx[p]];
        pipeData  <= rdData;
        pipeValid <= rdValid;
        clashQ    <= clash;
      end
    end

    assign dataValid[p] = cmd[p].pipe ? pipeValid : rdValid;
    assign dataOut[p]   = !dataValid[p] ? '0 : (cmd[p].pipe ? pipeData : rdData);
    assign clashFlag[p] = clashQ;
  end

endmodule

// File: rtl/bank_dpram.sv
module bank_dpram
  import bank_dpram_pkg::*;
#(
  parameter int BankBits = 6,
  parameter int WordBits = 4,
  parameter int DataBits = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pipeL,
  input  logic                ce0NL,
  input  logic                ce1L,
  input  logic                rdWrNL,
  input  logic                addrStbL,
  input  logic                cntEnL,
  input  logic                rptEnL,
  input  logic [BankBits-1:0] bankL,
  input  logic [WordBits-1:0] wordL,
  input  logic                ubNL,
  input  logic                lbNL,
  input  logic                oeNL,
  input  logic [DataBits-1:0] dinL,
  output logic [DataBits-1:0] doutL,
  output logic                validL,
  output logic                collL,
  input  logic                pipeR,
  input  logic                ce0NR,
  input  logic                ce1R,
  input  logic                rdWrNR,
  input  logic                addrStbR,
  input  logic                cntEnR,
  input  logic                rptEnR,
  input  logic [BankBits-1:0] bankR,
  input  logic [WordBits-1:0] wordR,
  input  logic                ubNR,
  input  logic                lbNR,
  input  logic                oeNR,
  input  logic [DataBits-1:0] dinR,
  output logic [DataBits-1:0] doutR,
  output logic                validR,
  output logic                collR
);

  // Index 0 is the left port, index 1 the right port
  logic [1:0]                pipeA, ce0NA, ce1A, rdWrNA, stbA, cenA, rptA, ubNA, lbNA, oeNA;
  logic [1:0][BankBits-1:0]  bankA;
  logic [1:0][WordBits-1:0]  wordA;
  logic [1:0][DataBits-1:0]  dinA;

  portCmd_t [1:0]            cmd;
  logic [1:0][BankBits-1:0]  bankQ;
  logic [1:0][WordBits-1:0]  wordQ;
  logic [1:0][DataBits-1:0]  dataQ;
  logic [1:0][DataBits-1:0]  dataOut;
  logic [1:0]                dataValid;
  logic [1:0]                clashFlag;

  assign pipeA  = {pipeR, pipeL};
  assign ce0NA  = {ce0NR, ce0NL};
  assign ce1A   = {ce1R, ce1L};
  assign rdWrNA = {rdWrNR, rdWrNL};
  assign stbA   = {addrStbR, addrStbL};
  assign cenA   = {cntEnR, cntEnL};
  assign rptA   = {rptEnR, rptEnL};
  assign ubNA   = {ubNR, ubNL};
  assign lbNA   = {lbNR, lbNL};
  assign oeNA   = {oeNR, oeNL};
  assign bankA  = {bankR, bankL};
  assign wordA  = {wordR, wordL};
  assign dinA   = {dinR, dinL};

  for (genvar p = 0; p < 2; p++) begin : g_port
    bank_dpram_port #(
      .BankBits(BankBits), .WordBits(WordBits), .DataBits(DataBits)
    ) u_port (
      .clk(clk), .rstN(rstN),
      .ce0N(ce0NA[p]), .ce1(ce1A[p]), .rdWrN(rdWrNA[p]),
      .addrStb(stbA[p]), .cntEn(cenA[p]), .rptEn(rptA[p]),
      .ubN(ubNA[p]), .lbN(lbNA[p]), .oeN(oeNA[p]), .pipeSel(pipeA[p]),
      .bankIn(bankA[p]), .wordIn(wordA[p]), .dataIn(dinA[p]),
      .cmd(cmd[p]), .bankQ(bankQ[p]), .wordQ(wordQ[p]), .dataQ(dataQ[p])
    );
  end

  bank_dpram_core #(
    .BankBits(BankBits), .WordBits(WordBits), .DataBits(DataBits)
  ) u_core (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .bankQ(bankQ), .wordQ(wordQ), .dataQ(dataQ),
    .dataOut(dataOut), .dataValid(dataValid), .clashFlag(clashFlag)
  );

  assign doutL  = dataOut[0];
  assign validL = dataValid[0];
  assign collL  = clashFlag[0];
  assign doutR  = dataOut[1];
  assign validR = dataValid[1];
  assign collR  = clashFlag[1];

endmodule

// File: rtl/bank_dpram_chk.sv
module bank_dpram_chk
  import bank_dpram_pkg::*;
#(
  parameter int BankBits = 6,
  parameter int WordBits = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     addrStbL,
  input logic                     cntEnL,
  input logic                     rptEnL,
  input logic [WordBits-1:0]      wordL,
  input portCmd_t [1:0]           cmd,
  input logic [1:0][BankBits-1:0] bankQ,
  input logic [1:0][WordBits-1:0] wordQ,
  input logic                     validL,
  input logic                     validR,
  input logic                     collL,
  input logic                     collR
);

  localparam logic [WordBits-1:0] WordOne = WordBits'(1);

  a_r8_strobe_load: assert property (@(posedge clk) disable iff (!rstN)
    addrStbL |=> (wordQ[0] == $past(wordL)));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStbL && !rptEnL && cntEnL) |=> (wordQ[0] == $past(wordQ[0]) + WordOne));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStbL && !rptEnL && !cntEnL) |=> $stable(wordQ[0]));

  a_r12_clash_flags: assert property (@(posedge clk) disable iff (!rstN)
    (cmd[0].sel && cmd[1].sel && bankQ[0] == bankQ[1]) |=> (collL && collR));

  a_r12_no_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd[0].sel && cmd[1].sel && bankQ[0] == bankQ[1]) |=> !collR);

  a_r6_flow_valid: assert property (@(posedge clk) disable iff (!rstN)
    (cmd[0].sel && !cmd[0].wr && cmd[0].oe && !cmd[0].pipe) |=> (validL || cmd[0].pipe));

  a_r4_unselected: assert property (@(posedge clk) disable iff (!rstN)
    !cmd[1].sel |=> (!validR || cmd[1].pipe));

endmodule

bind bank_dpram bank_dpram_chk #(.BankBits(BankBits), .WordBits(WordBits)) i_chk (.*);

// File: tb/test_bank_dpram.sv
`timescale 1ns/1ps
module test_bank_dpram;

  localparam int BB = 6;
  localparam int WB = 4;
  localparam int DB = 18;

  typedef struct packed {
    logic [5:0]  bk;
    logic [3:0]  wd;
    logic [17:0] d1;
    logic [17:0] d2;
    logic [1:0]  be;   // {upper, lower}, 1 = write that half
    logic [17:0] exp;
  } vec_t;

  localparam vec_t Vecs [5] = '{
    '{6'd0,  4'd0,  18'h3FFFF, 18'h00000, 2'b11, 18'h00000},
    '{6'd5,  4'd3,  18'h12345, 18'h3FFFF, 2'b10, 18'h3FF45},
    '{6'd63, 4'd15, 18'h0AAAA, 18'h15555, 2'b01, 18'h0AB55},
    '{6'd17, 4'd8,  18'h20001, 18'h1FFFF, 2'b00, 18'h20001},
    '{6'd40, 4'd1,  18'h00000, 18'h2ABCD, 2'b11, 18'h2ABCD}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce0N [2], ce1 [2], rdWrN [2], addrStb [2], cntEn [2], rptEn [2];
  logic ubN [2], lbN [2], oeN [2], pipeA [2];
  logic [BB-1:0] bank [2];
  logic [WB-1:0] word [2];
  logic [DB-1:0] din [2];
  logic [DB-1:0] dout [2];
  logic valid [2], coll [2];

  int nChk = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  bank_dpram #(.BankBits(BB), .WordBits(WB), .DataBits(DB)) i_bank_dpram (
    .clk(clk), .rstN(rstN),
    .pipeL(pipeA[0]), .ce0NL(ce0N[0]), .ce1L(ce1[0]), .rdWrNL(rdWrN[0]),
    .addrStbL(addrStb[0]), .cntEnL(cntEn[0]), .rptEnL(rptEn[0]),
    .bankL(bank[0]), .wordL(word[0]), .ubNL(ubN[0]), .lbNL(lbN[0]),
    .oeNL(oeN[0]), .dinL(din[0]), .doutL(dout[0]), .validL(valid[0]), .collL(coll[0]),
    .pipeR(pipeA[1]), .ce0NR(ce0N[1]), .ce1R(ce1[1]), .rdWrNR(rdWrN[1]),
    .addrStbR(addrStb[1]), .cntEnR(cntEn[1]), .rptEnR(rptEn[1]),
    .bankR(bank[1]), .wordR(word[1]), .ubNR(ubN[1]), .lbNR(lbN[1]),
    .oeNR(oeN[1]), .dinR(din[1]), .doutR(dout[1]), .validR(valid[1]), .collR(coll[1])
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input bit sel, input bit wr, input bit stb,
                       input bit cen, input bit rpt, input int bk, input int wd,
                       input logic [17:0] d, input bit [1:0] be, input bit oe);
    ce0N[p] = !sel;  ce1[p] = sel;  rdWrN[p] = !wr;
    addrStb[p] = stb;  cntEn[p] = cen;  rptEn[p] = rpt;
    bank[p] = bk[BB-1:0];  word[p] = wd[WB-1:0];  din[p] = d;
    ubN[p] = !be[1];  lbN[p] = !be[0];  oeN[p] = !oe;
  endtask

  task automatic idle(input int p);
    drive(p, 0, 0, 0, 0, 0, 0, 0, '0, 2'b00, 1);
  endtask

  task automatic singleWr(input int p, input int bk, input int wd,
                          input logic [17:0] d, input bit [1:0] be);
    drive(p, 1, 1, 1, 0, 0, bk, wd, d, be, 1);
    tick(); idle(p); tick();
  endtask

  task automatic singleRd(input int p, input int bk, input int wd,
                          input logic [17:0] exp, input string req);
    drive(p, 1, 0, 1, 0, 0, bk, wd, '0, 2'b00, 1);
    tick(); idle(p); tick();
    check({req, " valid"}, 32'(valid[p]), 32'd1);
    check({req, " data"}, 32'(dout[p]), 32'(exp));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual still running, expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p);
      pipeA[p] = 1'b0;
    end
    repeat (3) tick();
    // R1: reset values while reset is held and after release
    check("R1 validL in reset", 32'(valid[0]), 32'd0);
    check("R1 doutR in reset", 32'(dout[1]), 32'd0);
    rstN = 1'b1;
    repeat (2) tick();
    check("R1 validR", 32'(valid[1]), 32'd0);
    check("R1 doutL", 32'(dout[0]), 32'd0);
    check("R1 collL", 32'(coll[0]), 32'd0);
    check("R1 collR", 32'(coll[1]), 32'd0);

    // R2 R3 R5: vector table, full write then masked rewrite then read
    for (int i = 0; i < 5; i++) begin
      singleWr(0, int'(Vecs[i].bk), int'(Vecs[i].wd), Vecs[i].d1, 2'b11);
      singleWr(0, int'(Vecs[i].bk), int'(Vecs[i].wd), Vecs[i].d2, Vecs[i].be);
      singleRd(0, int'(Vecs[i].bk), int'(Vecs[i].wd), Vecs[i].exp, "R2 R3 R5 table");
    end
    // R2: first entry untouched by the writes that followed
    singleRd(1, 0, 0, 18'h00000, "R2 other words kept");

    // R9: burst writes 14, 15, then wrap to 0 in bank 2
    drive(0, 1, 1, 1, 0, 0, 2, 14, 18'h00A0A, 2'b11, 1); tick();
    drive(0, 1, 1, 0, 1, 0, 2, 0, 18'h00B0B, 2'b11, 1); tick();
    drive(0, 1, 1, 0, 1, 0, 2, 0, 18'h00C0C, 2'b11, 1); tick();
    idle(0); tick();
    singleRd(0, 2, 0, 18'h00C0C, "R9 wrap to word 0");
    singleRd(0, 2, 15, 18'h00B0B, "R9 step");
    singleRd(0, 2, 14, 18'h00A0A, "R8 strobe load");

    // R6 R10: back-to-back reads with step, repeat and strobe priority
    drive(0, 1, 0, 1, 0, 0, 2, 14, '0, 2'b00, 1); tick();
    drive(0, 1, 0, 0, 1, 0, 2, 0, '0, 2'b00, 1); tick();
    check("R6 flow read word 14", 32'(dout[0]), 32'h00A0A);
    drive(0, 1, 0, 0, 1, 1, 2, 0, '0, 2'b00, 1); tick();
    check("R9 read step word 15", 32'(dout[0]), 32'h00B0B);
    drive(0, 1, 0, 1, 0, 1, 2, 0, '0, 2'b00, 1); tick();
    check("R10 repeat over step", 32'(dout[0]), 32'h00A0A);
    idle(0); tick();
    check("R10 strobe over repeat", 32'(dout[0]), 32'h00C0C);

    // R9: no strobe, step or repeat keeps the address
    drive(0, 1, 0, 1, 0, 0, 2, 15, '0, 2'b00, 1); tick(); idle(0); tick();
    drive(0, 1, 0, 0, 0, 0, 2, 3, '0, 2'b00, 1); tick(); idle(0); tick();
    check("R9 hold address", 32'(dout[0]), 32'h00B0B);

    // R4: chip enables
    singleWr(0, 3, 7, 18'h3FFFF, 2'b11);
    drive(0, 1, 1, 1, 0, 0, 3, 7, 18'h00000, 2'b11, 1); ce0N[0] = 1'b1;
    tick(); idle(0); tick();
    drive(0, 1, 1, 1, 0, 0, 3, 7, 18'h00000, 2'b11, 1); ce1[0] = 1'b0;
    tick(); idle(0); tick();
    drive(0, 1, 0, 1, 0, 0, 3, 7, '0, 2'b00, 1); ce1[0] = 1'b0;
    tick(); idle(0); tick();
    check("R4 unselected read valid", 32'(valid[0]), 32'd0);
    check("R4 unselected read data", 32'(dout[0]), 32'd0);
    singleRd(0, 3, 7, 18'h3FFFF, "R4 unselected writes ignored");

    // R11: output disabled
    drive(0, 1, 0, 1, 0, 0, 3, 7, '0, 2'b00, 0); tick(); idle(0); tick();
    check("R11 oe off valid", 32'(valid[0]), 32'd0);
    check("R11 oe off data", 32'(dout[0]), 32'd0);

    // R12: same-bank collisions
    singleWr(1, 9, 2, 18'h11111, 2'b11);
    singleWr(0, 9, 3, 18'h22222, 2'b11);
    singleRd(1, 9, 3, 18'h22222, "R2 right port read");
    drive(0, 1, 1, 1, 0, 0, 9, 2, 18'h0AAAA, 2'b11, 1);
    drive(1, 1, 1, 1, 0, 0, 9, 2, 18'h15555, 2'b11, 1);
    tick(); idle(0); idle(1); tick();
    check("R12 collL raised", 32'(coll[0]), 32'd1);
    check("R12 collR raised", 32'(coll[1]), 32'd1);
    tick();
    check("R12 collR one cycle", 32'(coll[1]), 32'd0);
    singleRd(0, 9, 2, 18'h0AAAA, "R12 left write kept");
    drive(0, 1, 0, 1, 0, 0, 9, 3, '0, 2'b00, 1);
    drive(1, 1, 0, 1, 0, 0, 9, 2, '0, 2'b00, 1);
    tick(); idle(0); idle(1); tick();
    check("R12 left read served", 32'(dout[0]), 32'h22222);
    check("R12 right read valid", 32'(valid[1]), 32'd1);
    check("R12 right read repeats", 32'(dout[1]), 32'h22222);

    // R13: different banks at once
    drive(0, 1, 1, 1, 0, 0, 20, 5, 18'h13579, 2'b11, 1);
    drive(1, 1, 1, 1, 0, 0, 21, 5, 18'h2468A, 2'b11, 1);
    tick(); idle(0); idle(1); tick();
    check("R13 no collision", 32'(coll[1]), 32'd0);
    drive(0, 1, 0, 1, 0, 0, 21, 5, '0, 2'b00, 1);
    drive(1, 1, 1, 1, 0, 0, 22, 5, 18'h3C3C3, 2'b11, 1);
    tick(); idle(0); idle(1); tick();
    check("R13 left read beside right write", 32'(dout[0]), 32'h2468A);
    singleRd(0, 22, 5, 18'h3C3C3, "R13 right write stored");

    // R7: pipelined right port
    pipeA[1] = 1'b1;
    repeat (3) tick();
    drive(1, 1, 0, 1, 0, 0, 20, 5, '0, 2'b00, 1); tick(); idle(1); tick();
    check("R7 not yet valid", 32'(valid[1]), 32'd0);
    tick();
    check("R7 pipelined valid", 32'(valid[1]), 32'd1);
    check("R7 pipelined data", 32'(dout[1]), 32'h13579);
    pipeA[1] = 1'b0;
    repeat (2) tick();

    summary();
    $finish;
  end

endmodule